// File: doc/BRIEF.md
# System Clock Source Selector and Power-of-Two Divider

This block sits just after an analog PLL and produces the chip's system clock. It chooses between the reference oscillator clock and the PLL VCO output. A post-divider then scales the chosen clock down by a power of two, and software may change that divider at any time. The block also turns the PLL enable bit, the keep-running-in-stop bit and the stop request into a PLL power-down request. The source switch is glitch-free, and it never hands the output to the VCO before the lock flag has been seen high.

Software-facing control fields are taken as synchronous to the reference clock. The lock flag is treated as asynchronous. The divider runs on the muxed clock and carries the division exponent across into that domain itself. The block also decodes three PLL setting fields (output divider code, input divider field and feedback multiplier field) into plain ratios for the analog macro and for monitoring logic.

Top module: `sysclk_gen`

## Requirements
- R1: After reset the output runs from the reference clock, divided by 1, and `pll_pd` is 1.
- R2: `sys_clk` equals the selected source clock divided by 2^`div_exp`, for every `div_exp` value from 0 to 7.
- R3: A new `div_exp` value is applied only at the end of a complete output period. No `sys_clk` pulse is shorter than half the period of the faster of the old and new settings. Divider changes never alter `pll_pd`.
- R4: When `pll_en`=0 and `stop_keep`=0, the output runs from the reference clock and `pll_pd`=1. `pll_pd` is never 1 while the VCO branch drives the output.
- R5: The source switch is break-before-make. The two branches are never enabled together, and the output stays low during the gap between them. Rapid toggling of `pll_en` produces no pulse shorter than half a VCO period.
- R6: With `pll_en`=1 and no stop, the output stays on the reference clock while `pll_lock`=0, and `pll_pd`=0. Once `pll_lock`=1, the output moves to the VCO.
- R7: With `stop_keep`=0, a stop request powers the PLL down (`pll_pd`=1) and moves the output to the reference clock.
- R8: With `stop_keep`=1, the PLL keeps running (`pll_pd`=0) in every state. The VCO is used if `pll_en`=1; if `pll_en`=0 the PLL is bypassed and the output uses the reference clock.
- R9: The decoded outputs are as follows. `post_div_ratio` is 1, 2, 4 or 8 for `od_code` 00, 01, 10 or 11. `in_div_ratio` is `pre_div_code`+1 (1 to 32). `fb_mul_ratio` is `mul_code`+1 (1 to 256). `sys_div_ratio` is 2^`div_exp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference oscillator clock; control fields are synchronous to it |
| vco_clk | input | 1 | PLL VCO output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_en | input | 1 | Use the PLL output when locked |
| stop_keep | input | 1 | Keep the PLL running through the stop state |
| div_exp | input | 3 | Post-divider exponent; the ratio is 2^div_exp |
| od_code | input | 2 | PLL output divider code |
| pre_div_code | input | 5 | PLL input divider field |
| mul_code | input | 8 | PLL feedback multiplier field |
| stop_req | input | 1 | System stop state request |
| pll_lock | input | 1 | PLL lock flag (asynchronous) |
| sys_clk | output | 1 | System clock |
| pll_pd | output | 1 | PLL power-down request |
| sys_div_ratio | output | 8 | Decoded post-divider ratio |
| post_div_ratio | output | 4 | Decoded PLL output divider ratio |
| in_div_ratio | output | 6 | Decoded PLL input divider ratio |
| fb_mul_ratio | output | 9 | Decoded PLL feedback multiplier ratio |

## Verification
The bench sweeps every divider exponent on both sources, measuring the period at each step. It also tracks the narrowest pulse seen over the whole run, so a divider that switched mid-period, or a mux with overlapping or racing enables, would show up as a runt pulse. It raises `pll_en` while the lock flag is low, expecting the output to stay on the reference clock; a design that trusted the enable bit alone would jump to an unlocked VCO. It walks through the stop and keep combinations, watching for a power-down asserted while the VCO still feeds the output, or a PLL wrongly kept or dropped. It then toggles the enable in bursts faster than the handshake settles, which is where a switch without settled-request gating would enable both branches.

// File: rtl/sysclk_gen_pkg.sv
// Package: shared constants and the PLL power policy for the system clock block.
package sysclk_gen_pkg;

    // Depth of every clock-domain-crossing synchroniser in the block.
    localparam int unsigned SYNC_DEPTH = 2;

    // PLL power-down policy: off unless kept alive, and off when disabled or stopping.
    function automatic logic pd_policy(input logic en, input logic keep, input logic stop);
        return ~keep & (~en | stop);
    endfunction

endpackage

// File: rtl/sysclk_sync.sv
// Module: multi-bit flop-chain synchroniser.
// Assumes: WIDTH > 1 only for buses that are stable long enough to be qualified downstream.
module sysclk_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the sampled value through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sysclk_ratio_decode.sv
// Module: turns PLL and post-divider setting fields into plain ratio values.
// Assumes: purely combinational; the consumer samples it in its own domain.
module sysclk_ratio_decode #(
    parameter int unsigned DF_W = 3,
    parameter int unsigned OD_W = 2,
    parameter int unsigned NR_W = 5,
    parameter int unsigned NF_W = 8
) (
    input  logic [DF_W-1:0]        div_exp,
    input  logic [OD_W-1:0]        od_code,
    input  logic [NR_W-1:0]        pre_div_code,
    input  logic [NF_W-1:0]        mul_code,
    output logic [(1<<DF_W)-1:0]   sys_div_ratio,
    output logic [(1<<OD_W)-1:0]   post_div_ratio,
    output logic [NR_W:0]          in_div_ratio,
    output logic [NF_W:0]          fb_mul_ratio
);

    localparam int unsigned DFR_W = 1 << DF_W;
    localparam int unsigned ODR_W = 1 << OD_W;

    // One-hot power-of-two ratios and plus-one field ratios.
    always_comb begin
        sys_div_ratio  = DFR_W'(1) << div_exp;
        post_div_ratio = ODR_W'(1) << od_code;
        in_div_ratio   = (NR_W+1)'(pre_div_code) + (NR_W+1)'(1);
        fb_mul_ratio   = (NF_W+1)'(mul_code) + (NF_W+1)'(1);
    end

endmodule

// File: rtl/sysclk_src_switch.sv
// Module: break-before-make source switch between the reference and VCO clocks,
// plus the PLL power-down request.
// Assumes: pll_en, stop_keep, stop_req are synchronous to ref_clk; pll_lock is async.
// Branch enables change on falling edges so the AND-OR mux never cuts a high phase.
module sysclk_src_switch import sysclk_gen_pkg::*; #(
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
    input  logic ref_clk,
    input  logic vco_clk,
    input  logic rst_n,
    input  logic pll_en,
    input  logic stop_keep,
    input  logic stop_req,
    input  logic pll_lock,
    output logic en_ref,
    output logic en_vco,
    output logic pll_pd
);

    logic lock_s;      // lock flag seen in the reference domain
    logic vco_on_s;    // VCO branch enable seen in the reference domain
    logic go_q;        // registered request for the VCO branch
    logic go_s;        // that request seen in the VCO domain
    logic want_q;      // settled source choice: 1 = VCO
    logic pd_q;
    logic pd_pol;
    logic target;
    logic settled;

    sysclk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_lock_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(pll_lock), .q(lock_s));

    sysclk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_vco_on_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(en_vco), .q(vco_on_s));

    sysclk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_go_sync (
        .clk(vco_clk), .rst_n(rst_n), .d(go_q), .q(go_s));

    // Policy, desired source, and whether the last handover has fully completed.
    always_comb begin
        pd_pol  = pd_policy(pll_en, stop_keep, stop_req);
        target  = pll_en & ~pd_pol & lock_s;
        settled = want_q ? vco_on_s : (en_ref & ~vco_on_s);
    end

    // Reference-domain control: source choice, VCO request, power-down request.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            want_q <= 1'b0;
            go_q   <= 1'b0;
            pd_q   <= 1'b1;
        end else begin
            if (settled) begin
                want_q <= target;
            end
            go_q <= want_q & ~en_ref;
            pd_q <= pd_pol & ~want_q & en_ref & ~vco_on_s;
        end
    end

    // Reference branch enable, opened only once the VCO branch is seen closed.
    always_ff @(negedge ref_clk) begin
        if (!rst_n) begin
            en_ref <= 1'b1;
        end else begin
            en_ref <= ~want_q & ~vco_on_s;
        end
    end

    // VCO branch enable, opened only after the reference branch has closed.
    always_ff @(negedge vco_clk) begin
        if (!rst_n) begin
            en_vco <= 1'b0;
        end else begin
            en_vco <= go_s;
        end
    end

    assign pll_pd = pd_q;

endmodule

// File: rtl/sysclk_pow2_div.sv
// Module: power-of-two post-divider with 50% duty for exponents of 1 and up.
// Assumes: clk_in is the muxed source; div_exp is async to it and quasi-static.
// A new exponent is loaded on a falling edge that ends a full output period,
// when both the source and the divided clock are low.
module sysclk_pow2_div import sysclk_gen_pkg::*; #(
    parameter int unsigned DF_W = 3
) (
    input  logic            clk_in,
    input  logic            rst_n,
    input  logic [DF_W-1:0] div_exp,
    output logic [DF_W-1:0] df_cur,
    output logic            div_q
);

    localparam int unsigned MAX_EXP = (1 << DF_W) - 1;
    localparam int unsigned CNT_W   = (MAX_EXP > 1) ? (MAX_EXP - 1) : 1;

    logic [DF_W-1:0]  df_s;
    logic [DF_W-1:0]  df_s_d;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic             bnd_q;
    logic             df_ok;

    sysclk_sync #(.WIDTH(DF_W), .STAGES(SYNC_DEPTH)) u_df_sync (
        .clk(clk_in), .rst_n(rst_n), .d(div_exp), .q(df_s));

    // Half-period length minus one for the active exponent.
    always_comb begin
        half_m1 = '0;
        for (int k = 1; k <= int'(MAX_EXP); k++) begin
            if (df_cur == DF_W'(k)) begin
                half_m1 = CNT_W'((1 << (k - 1)) - 1);
            end
        end
        df_ok = (df_s == df_s_d);
    end

    // Half-period counter, divided clock and period-end marker.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            cnt    <= '0;
            div_q  <= 1'b0;
            bnd_q  <= 1'b1;
            df_s_d <= '0;
        end else begin
            df_s_d <= df_s;
            if (df_cur == '0) begin
                cnt   <= '0;
                div_q <= 1'b0;
                bnd_q <= 1'b1;
            end else if (cnt == half_m1) begin
                cnt   <= '0;
                div_q <= ~div_q;
                bnd_q <= div_q;
            end else begin
                cnt   <= cnt + CNT_W'(1);
                bnd_q <= 1'b0;
            end
        end
    end

    // Load a stable new exponent only at a period end, while everything is low.
    always_ff @(negedge clk_in) begin
        if (!rst_n) begin
            df_cur <= '0;
        end else if (bnd_q && df_ok) begin
            df_cur <= df_s;
        end
    end

endmodule

// File: rtl/sysclk_gen.sv
// Module: system clock generator top - source switch, AND-OR clock mux,
// power-of-two divider and setting decode.
// Assumes: both clocks run during reset; control fields are synchronous to ref_clk.
module sysclk_gen import sysclk_gen_pkg::*; #(
    parameter int unsigned DF_W = 3,
    parameter int unsigned OD_W = 2,
    parameter int unsigned NR_W = 5,
    parameter int unsigned NF_W = 8
) (
    input  logic                  ref_clk,
    input  logic                  vco_clk,
    input  logic                  rst_n,
    input  logic                  pll_en,
    input  logic                  stop_keep,
    input  logic [DF_W-1:0]       div_exp,
    input  logic [OD_W-1:0]       od_code,
    input  logic [NR_W-1:0]       pre_div_code,
    input  logic [NF_W-1:0]       mul_code,
    input  logic                  stop_req,
    input  logic                  pll_lock,
    output logic                  sys_clk,
    output logic                  pll_pd,
    output logic [(1<<DF_W)-1:0]  sys_div_ratio,
    output logic [(1<<OD_W)-1:0]  post_div_ratio,
    output logic [NR_W:0]         in_div_ratio,
    output logic [NF_W:0]         fb_mul_ratio
);

    logic            en_ref;
    logic            en_vco;
    logic            clk_mux;
    logic [DF_W-1:0] df_cur;
    logic            div_q;

    sysclk_src_switch #(.SYNC_STAGES(SYNC_DEPTH)) i_switch (
        .ref_clk   (ref_clk),
        .vco_clk   (vco_clk),
        .rst_n     (rst_n),
        .pll_en    (pll_en),
        .stop_keep (stop_keep),
        .stop_req  (stop_req),
        .pll_lock  (pll_lock),
        .en_ref    (en_ref),
        .en_vco    (en_vco),
        .pll_pd    (pll_pd)
    );

    // AND-OR clock mux; enables only move while their own clock is low.
    assign clk_mux = (ref_clk & en_ref) | (vco_clk & en_vco);

    sysclk_pow2_div #(.DF_W(DF_W)) i_div (
        .clk_in  (clk_mux),
        .rst_n   (rst_n),
        .div_exp (div_exp),
        .df_cur  (df_cur),
        .div_q   (div_q)
    );

    // Exponent 0 passes the muxed clock; the select moves only while both inputs are low.
    assign sys_clk = (df_cur == '0) ? clk_mux : div_q;

    sysclk_ratio_decode #(.DF_W(DF_W), .OD_W(OD_W), .NR_W(NR_W), .NF_W(NF_W)) i_decode (
        .div_exp        (div_exp),
        .od_code        (od_code),
        .pre_div_code   (pre_div_code),
        .mul_code       (mul_code),
        .sys_div_ratio  (sys_div_ratio),
        .post_div_ratio (post_div_ratio),
        .in_div_ratio   (in_div_ratio),
        .fb_mul_ratio   (fb_mul_ratio)
    );

endmodule

// File: rtl/sysclk_gen_chk.sv
// Checker: temporal properties of the system clock generator, bound into the top.
module sysclk_gen_chk #(
    parameter int unsigned DF_W = 3
) (
    input logic            ref_clk,
    input logic            vco_clk,
    input logic            clk_mux,
    input logic            rst_n,
    input logic            en_ref,
    input logic            en_vco,
    input logic            pll_pd,
    input logic            stop_keep,
    input logic [DF_W-1:0] df_cur,
    input logic            div_q
);

    // R5: the two branch enables never overlap (seen from each domain)
    assert_src_exclusive_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(en_ref && en_vco));

    assert_src_exclusive_vco_R5: assert property (@(posedge vco_clk) disable iff (!rst_n)
        !(en_ref && en_vco));

    // R4: no power-down while the VCO branch feeds the output
    assert_pd_not_on_vco_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        pll_pd |-> !en_vco);

    // R3: the divider exponent only moves at a period end, with the divided clock low
    assert_df_on_boundary_R3: assert property (@(posedge clk_mux) disable iff (!rst_n)
        !$stable(df_cur) |-> !div_q);

    // R8: keeping the PLL alive drops the power-down request on the next cycle
    assert_keep_no_pd_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        stop_keep |=> !pll_pd);

endmodule

bind sysclk_gen sysclk_gen_chk #(.DF_W(DF_W)) u_chk (
    .ref_clk   (ref_clk),
    .vco_clk   (vco_clk),
    .clk_mux   (clk_mux),
    .rst_n     (rst_n),
    .en_ref    (en_ref),
    .en_vco    (en_vco),
    .pll_pd    (pll_pd),
    .stop_keep (stop_keep),
    .df_cur    (df_cur),
    .div_q     (div_q)
);

// File: tb/test_sysclk_gen.sv
`timescale 1ns/1ps
// Directed bench for sysclk_gen: reference clock at 200 MHz, VCO modelled at 3 ns.
module test_sysclk_gen;

    localparam real REF_P = 5.0;
    localparam real VCO_P = 3.0;

    logic       ref_clk = 1'b0;
    logic       vco_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_en = 1'b0;
    logic       stop_keep = 1'b0;
    logic [2:0] div_exp = '0;
    logic [1:0] od_code = '0;
    logic [4:0] pre_div_code = '0;
    logic [7:0] mul_code = '0;
    logic       stop_req = 1'b0;
    logic       pll_lock = 1'b0;
    logic       sys_clk;
    logic       pll_pd;
    logic [7:0] sys_div_ratio;
    logic [3:0] post_div_ratio;
    logic [5:0] in_div_ratio;
    logic [8:0] fb_mul_ratio;

    int  checks = 0;
    int  errors = 0;
    bit  mon_en = 1'b0;
    real min_w = 1.0e9;

    always #2.5 ref_clk = ~ref_clk;
    always #1.5 vco_clk = ~vco_clk;

    sysclk_gen i_sysclk_gen (
        .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n), .pll_en(pll_en),
        .stop_keep(stop_keep), .div_exp(div_exp), .od_code(od_code),
        .pre_div_code(pre_div_code), .mul_code(mul_code), .stop_req(stop_req),
        .pll_lock(pll_lock), .sys_clk(sys_clk), .pll_pd(pll_pd),
        .sys_div_ratio(sys_div_ratio), .post_div_ratio(post_div_ratio),
        .in_div_ratio(in_div_ratio), .fb_mul_ratio(fb_mul_ratio));

    // Narrowest high or low phase of sys_clk since monitoring began.
    initial begin
        real last;
        bit  have;
        have = 1'b0;
        last = 0.0;
        wait (mon_en);
        forever begin
            @(sys_clk);
            if (have && (($realtime - last) < min_w)) min_w = $realtime - last;
            last = $realtime;
            have = 1'b1;
        end
    end

    task automatic check_int(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_real(input string tag, input real act, input real exp);
        checks++;
        if ((act - exp > 0.01) || (exp - act > 0.01)) begin
            errors++;
            $display("FAIL %s actual %0.3f expected %0.3f", tag, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic measure_period(output real p);
        real t0;
        @(posedge sys_clk);
        t0 = $realtime;
        @(posedge sys_clk);
        p = $realtime - t0;
    endtask

    task automatic check_clock(input string tag, input real exp);
        real p;
        measure_period(p);
        check_real(tag, p, exp);
        measure_period(p);
        check_real(tag, p, exp);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        wait_ref(12);
        rst_n = 1'b1;
        wait_ref(4);
        mon_en = 1'b1;
        check_int("R1 pll_pd after reset", pll_pd, 1);
        check_clock("R1 period after reset", REF_P);
    endtask

    // R9: decoded ratios
    task automatic t_decode();
        for (int c = 0; c < 4; c++) begin
            @(negedge ref_clk);
            od_code = 2'(c);
            #1;
            check_int("R9 post_div_ratio", post_div_ratio, 1 << c);
        end
        @(negedge ref_clk);
        pre_div_code = 5'd0; mul_code = 8'd0; div_exp = 3'd7;
        #1;
        check_int("R9 in_div_ratio min", in_div_ratio, 1);
        check_int("R9 fb_mul_ratio min", fb_mul_ratio, 1);
        check_int("R9 sys_div_ratio max", sys_div_ratio, 128);
        @(negedge ref_clk);
        pre_div_code = 5'd31; mul_code = 8'd255; div_exp = 3'd3;
        #1;
        check_int("R9 in_div_ratio max", in_div_ratio, 32);
        check_int("R9 fb_mul_ratio max", fb_mul_ratio, 256);
        check_int("R9 sys_div_ratio mid", sys_div_ratio, 8);
        @(negedge ref_clk);
        div_exp = 3'd0;
        wait_ref(300);
    endtask

    // R2 / R3: sweep the exponent on the current source
    task automatic t_df_sweep(input string tag, input real src_p, input int exp_pd);
        for (int d = 0; d < 8; d++) begin
            @(negedge ref_clk);
            div_exp = 3'(d);
            wait_ref(300);
            check_clock({"R2 divided period ", tag}, src_p * real'(1 << d));
            @(negedge ref_clk);
            check_int({"R3 pll_pd unchanged by divider ", tag}, pll_pd, exp_pd);
        end
        @(negedge ref_clk);
        div_exp = 3'd0;
        wait_ref(300);
        check_clock({"R2 back to ratio 1 ", tag}, src_p);
    endtask

    // R6: enable with and without lock
    task automatic t_lock_gate();
        @(negedge ref_clk);
        pll_en = 1'b1; pll_lock = 1'b0;
        wait_ref(60);
        check_int("R6 pll_pd low when enabled", pll_pd, 0);
        check_clock("R6 stays on reference while unlocked", REF_P);
        @(negedge ref_clk);
        pll_lock = 1'b1;
        wait_ref(60);
        check_clock("R6 moves to VCO once locked", VCO_P);
        @(negedge ref_clk);
        check_int("R6 pll_pd low on VCO", pll_pd, 0);
    endtask

    // R7 / R8 / R4: stop-state and enable policy
    task automatic t_stop_policy();
        @(negedge ref_clk);
        stop_keep = 1'b0; stop_req = 1'b1;
        wait_ref(60);
        check_int("R7 stop powers PLL down", pll_pd, 1);
        check_clock("R7 stop runs from reference", REF_P);
        @(negedge ref_clk);
        stop_req = 1'b0;
        wait_ref(60);
        check_clock("R6 VCO again after stop", VCO_P);
        @(negedge ref_clk);
        stop_keep = 1'b1; stop_req = 1'b1;
        wait_ref(60);
        check_int("R8 keep holds PLL up in stop", pll_pd, 0);
        check_clock("R8 keep stays on VCO in stop", VCO_P);
        @(negedge ref_clk);
        stop_req = 1'b0; pll_en = 1'b0;
        wait_ref(60);
        check_int("R8 bypass keeps PLL up", pll_pd, 0);
        check_clock("R8 bypass runs from reference", REF_P);
        @(negedge ref_clk);
        stop_keep = 1'b0;
        wait_ref(60);
        check_int("R4 disabled powers PLL down", pll_pd, 1);
        check_clock("R4 disabled runs from reference", REF_P);
    endtask

    // R5: bursts of enable toggling faster than the handshake
    task automatic t_toggle();
        for (int i = 0; i < 24; i++) begin
            @(negedge ref_clk);
            pll_en = ~pll_en;
            wait_ref((i % 7) + 1);
        end
        @(negedge ref_clk);
        pll_en = 1'b1;
        wait_ref(80);
        check_clock("R5 settles on VCO after toggling", VCO_P);
        check_real("R5 narrowest pulse over run", (min_w < 1.49) ? min_w : VCO_P / 2.0, VCO_P / 2.0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge ref_clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_decode();
        t_df_sweep("on reference", REF_P, 1);
        check_real("R3 narrowest pulse on reference", (min_w < 2.49) ? min_w : REF_P / 2.0, REF_P / 2.0);
        t_lock_gate();
        t_df_sweep("on VCO", VCO_P, 0);
        t_stop_policy();
        t_toggle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule